// File: doc/BRIEF.md
# Two-Wire Word Register Slave

This block is a slave on a two-wire SMBus-style bus. It holds a small bank of 16-bit control registers for nearby core logic. The bus lines are open-drain. Each line reaches the block as a plain input level. The block pulls SDA low through a single enable output. The system clock samples both lines through a two-flop synchroniser. Start and Stop are recognised as SDA edges while SCL is high.

A write is a single transaction made of four bytes:
- a control byte carrying the 7-bit slave address with R/W = 0,
- a register address byte,
- the low data byte,
- the high data byte.

The slave acknowledges each of these bytes. The new value is applied only when the master closes the transaction with Stop. At that point a one-cycle strobe tells the core which register changed.

A read takes two transactions. The first is an address-only write ended by Stop. The second starts with a control byte with R/W = 1. The slave then returns the selected word low byte first, and the master does not acknowledge the high byte. Only one register is moved per transaction.

Three registers are writable: charge current, charge voltage and input current. Two read-only identification words are also readable.

Top module: `smbwWordSlave`

## Requirements
- R1: After reset all three writable registers read 0x0000, `sdaDrvLow` is 0 and `wrStrobe` is 0.
- R2: A write transaction updates the addressed register to {high,low}. The transaction is: control byte {SLAVE_ADDR, 0}, address byte, low data byte, high data byte, then Stop. The slave ACKs all four bytes. For example, 0xA0 followed by 0x41 to address 0x14 gives 0x41A0. The writable addresses are 0x14 (charge current), 0x15 (charge voltage) and 0x3F (input current).
- R3: A register output and its strobe change only after Stop. After both data bytes have been ACKed and before Stop, the old value is still present. `wrStrobe` pulses for exactly one cycle per committed write: bit 0 for 0x14, bit 1 for 0x15, bit 2 for 0x3F.
- R4: A read returns the register selected by the most recent address byte. The read is: an address-only write ended by Stop, then Start and control byte {SLAVE_ADDR, 1}, which is ACKed. The slave then sends the low byte and then the high byte, each MSB first.
- R5: Address 0xFE reads parameter ID_MFR and address 0xFF reads parameter ID_DEV. Writes to either address are ACKed but change no register and raise no strobe.
- R6: Any other address is ACKed on write but leaves all registers unchanged with no strobe, and reads of it return 0x0000.
- R7: A control byte whose upper seven bits differ from SLAVE_ADDR is not ACKed. The slave then ignores the bus, ACKing nothing and changing nothing, until the next Start.
- R8: A byte sent after the high data byte is not ACKed, and Stop still commits the first two data bytes. A byte the master reads after the high byte returns 0xFF, because SDA is released.
- R9: A write that is cut short does not change any register. This covers a Stop after only the low data byte and a Start partway through the high data byte.
- R10: If the master does not ACK the low byte of a read, the slave stops sending, and a further byte read returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Level of the bus clock line |
| sdaIn | input | 1 | Level of the bus data line |
| sdaDrvLow | output | 1 | 1 pulls the data line low |
| chargeCurrent | output | 16 | Register at address 0x14 |
| chargeVoltage | output | 16 | Register at address 0x15 |
| inputCurrent | output | 16 | Register at address 0x3F |
| wrStrobe | output | 3 | One-cycle commit pulse per writable register |

## Verification
The hardest situations to reach are aborted transactions, where a Start or Stop lands in the middle of a write after some bytes were already ACKed. A register value must still not be applied. The bench master can issue a Stop after the low data byte, and it can break off the high byte after four bits with a Start condition. After each of these it checks all register outputs and the strobe counts against a bench model. Random transactions then mix full writes, reads, partial writes and wrong slave addresses over all register addresses, including unknown ones.

// File: rtl/smbw_pkg.sv
package smbw_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int NUM_WR = 3;
  localparam int CNT_W  = $clog2(BYTE_W) + 1;

  localparam logic [BYTE_W-1:0] ADDR_MFR_ID = 8'hFE;
  localparam logic [BYTE_W-1:0] ADDR_DEV_ID = 8'hFF;

  // Writable register addresses, indexed by strobe bit position
  function automatic logic [BYTE_W-1:0] wrRegAddr(input int idx);
    case (idx)
      0:       wrRegAddr = 8'h14;
      1:       wrRegAddr = 8'h15;
      default: wrRegAddr = 8'h3F;
    endcase
  endfunction

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_RACK, ST_DONE
  } ctrlState_t;

  typedef enum logic [2:0] {
    PH_CTRL, PH_ADDR, PH_DLO, PH_DHI, PH_RLO, PH_RHI
  } phase_t;

  typedef struct packed {
    logic shiftIn;
    logic latchAddr;
    logic latchLo;
    logic latchHi;
    logic commit;
    logic loadTxLo;
    logic loadTxHi;
    logic shiftTx;
  } dpCtl_t;
endpackage

// File: rtl/smbwLineSync.sv
module smbwLineSync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLvl,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startSeen,
  output logic stopSeen
);
  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] sclPipe;
  logic [PIPE_W-1:0] sdaPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[PIPE_W-2:0], sclIn};
      sdaPipe <= {sdaPipe[PIPE_W-2:0], sdaIn};
    end
  end

  logic sclPrev;
  logic sdaPrev;

  assign sclLvl  = sclPipe[SYNC_STAGES-1];
  assign sdaLvl  = sdaPipe[SYNC_STAGES-1];
  assign sclPrev = sclPipe[SYNC_STAGES];
  assign sdaPrev = sdaPipe[SYNC_STAGES];

  assign sclRise   = sclLvl & ~sclPrev;
  assign sclFall   = ~sclLvl & sclPrev;
  assign startSeen = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
  assign stopSeen  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;
endmodule

// File: rtl/smbwCtrl.sv
module smbwCtrl
  import smbw_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h09
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startSeen,
  input  logic              stopSeen,
  input  logic              sdaLvl,
  input  logic [BYTE_W-1:0] rxByte,
  output dpCtl_t            ctl,
  output logic              ackDrive,
  output logic              txActive,
  output ctrlState_t        stateOut
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_TX  = CNT_W'(BYTE_W - 1);

  ctrlState_t       stateQ;
  phase_t           phaseQ;
  logic [CNT_W-1:0] bitCnt;
  logic             isReadQ;
  logic             wrPendQ;
  logic             mAckQ;

  logic byteDone;
  logic ackThis;
  logic addrMatch;

  assign byteDone  = (stateQ == ST_RX) && sclFall && (bitCnt == LAST_BIT);
  assign addrMatch = (rxByte[BYTE_W-1:1] == SLAVE_ADDR);
  assign ackThis   = (phaseQ == PH_CTRL) ? addrMatch : 1'b1;

  always_comb begin
    ctl           = '0;
    ctl.shiftIn   = (stateQ == ST_RX) && sclRise && (bitCnt < LAST_BIT);
    ctl.latchAddr = byteDone && (phaseQ == PH_ADDR);
    ctl.latchLo   = byteDone && (phaseQ == PH_DLO);
    ctl.latchHi   = byteDone && (phaseQ == PH_DHI);
    ctl.commit    = stopSeen && (stateQ == ST_DONE) && wrPendQ;
    ctl.loadTxLo  = (stateQ == ST_ACK) && sclFall && (phaseQ == PH_CTRL) && isReadQ;
    ctl.loadTxHi  = (stateQ == ST_RACK) && sclFall && mAckQ && (phaseQ == PH_RLO);
    ctl.shiftTx   = (stateQ == ST_TX) && sclFall;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      phaseQ   <= PH_CTRL;
      bitCnt   <= '0;
      isReadQ  <= 1'b0;
      wrPendQ  <= 1'b0;
      mAckQ    <= 1'b0;
      ackDrive <= 1'b0;
    end else if (startSeen) begin
      stateQ   <= ST_RX;
      phaseQ   <= PH_CTRL;
      bitCnt   <= '0;
      wrPendQ  <= 1'b0;
      ackDrive <= 1'b0;
    end else if (stopSeen) begin
      stateQ   <= ST_IDLE;
      wrPendQ  <= 1'b0;
      ackDrive <= 1'b0;
    end else begin
      case (stateQ)
        ST_RX: begin
          if (ctl.shiftIn) bitCnt <= bitCnt + 1'b1;
          if (byteDone) begin
            if (ackThis) begin
              stateQ   <= ST_ACK;
              ackDrive <= 1'b1;
              if (phaseQ == PH_CTRL) isReadQ <= rxByte[0];
            end else begin
              stateQ <= ST_IDLE;
            end
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            ackDrive <= 1'b0;
            bitCnt   <= '0;
            case (phaseQ)
              PH_CTRL: begin
                stateQ <= isReadQ ? ST_TX : ST_RX;
                phaseQ <= isReadQ ? PH_RLO : PH_ADDR;
              end
              PH_ADDR: begin
                stateQ <= ST_RX;
                phaseQ <= PH_DLO;
              end
              PH_DLO: begin
                stateQ <= ST_RX;
                phaseQ <= PH_DHI;
              end
              default: begin
                stateQ  <= ST_DONE;
                wrPendQ <= 1'b1;
              end
            endcase
          end
        end
        ST_TX: begin
          if (sclFall) begin
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == LAST_TX) stateQ <= ST_RACK;
          end
        end
        ST_RACK: begin
          if (sclRise) mAckQ <= ~sdaLvl;
          if (sclFall) begin
            bitCnt <= '0;
            if (mAckQ && (phaseQ == PH_RLO)) begin
              stateQ <= ST_TX;
              phaseQ <= PH_RHI;
            end else begin
              stateQ <= ST_DONE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign txActive = (stateQ == ST_TX);
  assign stateOut = stateQ;
endmodule

// File: rtl/smbwRegBank.sv
module smbwRegBank
  import smbw_pkg::*;
#(
  parameter logic [WORD_W-1:0] ID_MFR = 16'h4D31,
  parameter logic [WORD_W-1:0] ID_DEV = 16'h0007
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  dpCtl_t                       ctl,
  input  logic                         sdaLvl,
  output logic [BYTE_W-1:0]            rxByte,
  output logic                         txBit,
  output logic [NUM_WR-1:0][WORD_W-1:0] regBus,
  output logic [NUM_WR-1:0]            wrStrobe
);
  logic [BYTE_W-1:0] rxShift;
  logic [BYTE_W-1:0] addrPtr;
  logic [BYTE_W-1:0] dataLo;
  logic [BYTE_W-1:0] dataHi;
  logic [BYTE_W-1:0] txShift;
  logic [NUM_WR-1:0] hitVec;
  logic [WORD_W-1:0] readWord;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_WR; gi++) begin : g_hit
      assign hitVec[gi] = (addrPtr == wrRegAddr(gi));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      addrPtr <= '0;
      dataLo  <= '0;
      dataHi  <= '0;
    end else begin
      if (ctl.shiftIn)   rxShift <= {rxShift[BYTE_W-2:0], sdaLvl};
      if (ctl.latchAddr) addrPtr <= rxShift;
      if (ctl.latchLo)   dataLo  <= rxShift;
      if (ctl.latchHi)   dataHi  <= rxShift;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regBus   <= '0;
      wrStrobe <= '0;
    end else begin
      wrStrobe <= ctl.commit ? hitVec : '0;
      for (int i = 0; i < NUM_WR; i++) begin
        if (ctl.commit && hitVec[i]) regBus[i] <= {dataHi, dataLo};
      end
    end
  end

  always_comb begin
    readWord = '0;
    if (addrPtr == ADDR_MFR_ID) readWord = ID_MFR;
    if (addrPtr == ADDR_DEV_ID) readWord = ID_DEV;
    for (int i = 0; i < NUM_WR; i++) begin
      if (hitVec[i]) readWord = regBus[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '1;
    end else if (ctl.loadTxLo) begin
      txShift <= readWord[BYTE_W-1:0];
    end else if (ctl.loadTxHi) begin
      txShift <= readWord[WORD_W-1:BYTE_W];
    end else if (ctl.shiftTx) begin
      txShift <= {txShift[BYTE_W-2:0], 1'b1};
    end
  end

  assign rxByte = rxShift;
  assign txBit  = txShift[BYTE_W-1];
endmodule

// File: rtl/smbwWordSlave.sv
module smbwWordSlave
  import smbw_pkg::*;
#(
  parameter logic [6:0]        SLAVE_ADDR  = 7'h09,
  parameter logic [WORD_W-1:0] ID_MFR      = 16'h4D31,
  parameter logic [WORD_W-1:0] ID_DEV      = 16'h0007,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaDrvLow,
  output logic [WORD_W-1:0] chargeCurrent,
  output logic [WORD_W-1:0] chargeVoltage,
  output logic [WORD_W-1:0] inputCurrent,
  output logic [NUM_WR-1:0] wrStrobe
);
  logic sclLvl, sdaLvl, sclRise, sclFall, startSeen, stopSeen;
  logic ackDrive, txActive, txBit;
  logic [BYTE_W-1:0] rxByte;
  logic [NUM_WR-1:0][WORD_W-1:0] regBus;
  dpCtl_t     ctl;
  ctrlState_t ctrlState;

  smbwLineSync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclLvl(sclLvl), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen)
  );

  smbwCtrl #(.SLAVE_ADDR(SLAVE_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen), .sdaLvl(sdaLvl),
    .rxByte(rxByte), .ctl(ctl), .ackDrive(ackDrive), .txActive(txActive),
    .stateOut(ctrlState)
  );

  smbwRegBank #(.ID_MFR(ID_MFR), .ID_DEV(ID_DEV)) u_bank (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sdaLvl(sdaLvl),
    .rxByte(rxByte), .txBit(txBit), .regBus(regBus), .wrStrobe(wrStrobe)
  );

  assign sdaDrvLow     = ackDrive | (txActive & ~txBit);
  assign chargeCurrent = regBus[0];
  assign chargeVoltage = regBus[1];
  assign inputCurrent  = regBus[2];
endmodule

// File: rtl/smbwWordSlave_chk.sv
module smbwWordSlave_chk
  import smbw_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              sdaDrvLow,
  input logic [WORD_W-1:0] chargeCurrent,
  input logic [WORD_W-1:0] chargeVoltage,
  input logic [WORD_W-1:0] inputCurrent,
  input logic [NUM_WR-1:0] wrStrobe,
  input logic              sclLvl,
  input logic              stopSeen,
  input ctrlState_t        ctrlState
);
  // R2/R4: the slave moves SDA only while the synchronised SCL is low
  assert_sda_moves_scl_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    (sdaDrvLow != $past(sdaDrvLow)) |-> !sclLvl);

  // R3: at most one register committed at a time
  assert_strobe_onehot_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wrStrobe));

  // R3: a commit follows a Stop condition
  assert_strobe_after_stop_R3: assert property (@(posedge clk) disable iff (!rstN)
    (|wrStrobe) |-> $past(stopSeen));

  // R3: register outputs change only together with their strobe
  assert_cc_with_strobe_R3: assert property (@(posedge clk) disable iff (!rstN)
    (chargeCurrent != $past(chargeCurrent)) |-> wrStrobe[0]);
  assert_cv_with_strobe_R3: assert property (@(posedge clk) disable iff (!rstN)
    (chargeVoltage != $past(chargeVoltage)) |-> wrStrobe[1]);
  assert_ic_with_strobe_R3: assert property (@(posedge clk) disable iff (!rstN)
    (inputCurrent != $past(inputCurrent)) |-> wrStrobe[2]);

  // R7: an idle slave never pulls the data line
  assert_idle_released_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_IDLE) |-> !sdaDrvLow);
endmodule

bind smbwWordSlave smbwWordSlave_chk u_chk (
  .clk(clk), .rstN(rstN), .sdaDrvLow(sdaDrvLow),
  .chargeCurrent(chargeCurrent), .chargeVoltage(chargeVoltage),
  .inputCurrent(inputCurrent), .wrStrobe(wrStrobe),
  .sclLvl(sclLvl), .stopSeen(stopSeen), .ctrlState(ctrlState)
);

// File: tb/sim_smbwWordSlave.sv
`timescale 1ns/1ps
module sim_smbwWordSlave;
  localparam logic [6:0]  SA   = 7'h09;
  localparam logic [15:0] MFR  = 16'h4D31;
  localparam logic [15:0] DEV  = 16'h0007;
  localparam int          Q    = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic sdaLine;
  logic sdaDrvLow;
  logic [15:0] chargeCurrent, chargeVoltage, inputCurrent;
  logic [2:0] wrStrobe;

  always #4 clk = ~clk;
  assign sdaLine = mSda & ~sdaDrvLow;

  smbwWordSlave #(.SLAVE_ADDR(SA), .ID_MFR(MFR), .ID_DEV(DEV)) u0 (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine), .sdaDrvLow(sdaDrvLow),
    .chargeCurrent(chargeCurrent), .chargeVoltage(chargeVoltage),
    .inputCurrent(inputCurrent), .wrStrobe(wrStrobe)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;
  int sCnt[3];
  int eCnt[3];
  logic [15:0] mdl[3];

  initial for (int i = 0; i < 3; i++) sCnt[i] = 0;
  always @(negedge clk) for (int i = 0; i < 3; i++) if (wrStrobe[i] === 1'b1) sCnt[i]++;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Bench model
  function automatic int wrIdx(input logic [7:0] a);
    case (a)
      8'h14: wrIdx = 0;
      8'h15: wrIdx = 1;
      8'h3F: wrIdx = 2;
      default: wrIdx = -1;
    endcase
  endfunction

  function automatic logic [15:0] expRead(input logic [7:0] a);
    if (wrIdx(a) >= 0) expRead = mdl[wrIdx(a)];
    else if (a == 8'hFE) expRead = MFR;
    else if (a == 8'hFF) expRead = DEV;
    else expRead = 16'h0000;
  endfunction

  task automatic modelWrite(input logic [7:0] a, input logic [15:0] w);
    if (wrIdx(a) >= 0) begin
      mdl[wrIdx(a)] = w;
      eCnt[wrIdx(a)]++;
    end
  endtask

  function automatic logic [7:0] pickAddr(input int unsigned r);
    case (r % 7)
      0: pickAddr = 8'h14;
      1: pickAddr = 8'h15;
      2: pickAddr = 8'h3F;
      3: pickAddr = 8'hFE;
      4: pickAddr = 8'hFF;
      default: pickAddr = 8'h40 + 8'(r % 32);
    endcase
  endfunction

  task automatic checkAll(input string tag);
    chk({tag, " R3 chargeCurrent"}, chargeCurrent, mdl[0]);
    chk({tag, " R3 chargeVoltage"}, chargeVoltage, mdl[1]);
    chk({tag, " R3 inputCurrent"}, inputCurrent, mdl[2]);
    for (int i = 0; i < 3; i++) chk({tag, " R3 strobe count"}, 16'(sCnt[i]), 16'(eCnt[i]));
  endtask

  // Bus master primitives
  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1'b1; mScl = 1'b1; waitQ();
    mSda = 1'b0; waitQ();
    mScl = 1'b0; waitQ();
  endtask

  task automatic busStop();
    mSda = 1'b0; waitQ();
    mScl = 1'b1; waitQ();
    mSda = 1'b1; waitQ();
  endtask

  task automatic sendBit(input logic b);
    mSda = b; waitQ();
    mScl = 1'b1; waitQ(); waitQ();
    mScl = 1'b0; waitQ();
  endtask

  task automatic writeByte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
    mSda = 1'b1; waitQ();
    mScl = 1'b1; waitQ();
    ack = (sdaLine === 1'b0);
    waitQ();
    mScl = 1'b0; waitQ();
  endtask

  task automatic readByte(input logic ackIt, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      mSda = 1'b1; waitQ();
      mScl = 1'b1; waitQ();
      d[i] = sdaLine;
      waitQ();
      mScl = 1'b0; waitQ();
    end
    sendBit(~ackIt);
    mSda = 1'b1;
  endtask

  task automatic busWrite(input logic [6:0] sa, input logic [7:0] a,
                          input logic [15:0] w, output logic [3:0] acks);
    busStart();
    writeByte({sa, 1'b0}, acks[0]);
    writeByte(a, acks[1]);
    writeByte(w[7:0], acks[2]);
    writeByte(w[15:8], acks[3]);
    busStop();
  endtask

  task automatic busRead(input logic [7:0] a, output logic [15:0] w, output logic [2:0] acks);
    busStart();
    writeByte({SA, 1'b0}, acks[0]);
    writeByte(a, acks[1]);
    busStop();
    busStart();
    writeByte({SA, 1'b1}, acks[2]);
    readByte(1'b1, w[7:0]);
    readByte(1'b0, w[15:8]);
    busStop();
  endtask

  initial begin
    logic [3:0] wa;
    logic [2:0] ra;
    logic [15:0] rw;
    logic ak;
    logic [7:0] b0, b1, b2;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 3; i++) begin mdl[i] = 16'h0; eCnt[i] = 0; end
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R1: reset state
    chk("R1 chargeCurrent", chargeCurrent, 16'h0);
    chk("R1 chargeVoltage", chargeVoltage, 16'h0);
    chk("R1 inputCurrent", inputCurrent, 16'h0);
    chk("R1 sdaDrvLow", 16'(sdaDrvLow), 16'h0);
    chk("R1 wrStrobe", 16'(wrStrobe), 16'h0);

    // R2/R3: 0xA0 then 0x41, value held until Stop
    busStart();
    writeByte({SA, 1'b0}, wa[0]);
    writeByte(8'h14, wa[1]);
    writeByte(8'hA0, wa[2]);
    writeByte(8'h41, wa[3]);
    repeat (10) @(negedge clk);
    chk("R3 value before stop", chargeCurrent, 16'h0000);
    chk("R3 no strobe before stop", 16'(sCnt[0]), 16'd0);
    busStop();
    modelWrite(8'h14, 16'h41A0);
    chk("R2 write acks", 16'(wa), 16'hF);
    chk("R2 chargeCurrent", chargeCurrent, 16'h41A0);
    checkAll("R2 after write");

    // R4: read back, low byte first
    busRead(8'h14, rw, ra);
    chk("R4 read acks", 16'(ra), 16'h7);
    chk("R4 read word", rw, 16'h41A0);
    busWrite(SA, 8'h3F, 16'h1234, wa);
    modelWrite(8'h3F, 16'h1234);
    busRead(8'h3F, rw, ra);
    chk("R4 read inputCurrent", rw, 16'h1234);

    // R5: identification words, read-only
    busRead(8'hFE, rw, ra);
    chk("R5 mfr id", rw, MFR);
    busRead(8'hFF, rw, ra);
    chk("R5 dev id", rw, DEV);
    busWrite(SA, 8'hFE, 16'hBEEF, wa);
    chk("R5 write acked", 16'(wa), 16'hF);
    busRead(8'hFE, rw, ra);
    chk("R5 mfr id unchanged", rw, MFR);
    checkAll("R5 after write");

    // R6: unknown address
    busWrite(SA, 8'h20, 16'h5555, wa);
    chk("R6 write acked", 16'(wa), 16'hF);
    checkAll("R6 after write");
    busRead(8'h20, rw, ra);
    chk("R6 read zero", rw, 16'h0000);

    // R7: other slave address
    busWrite(SA ^ 7'h01, 8'h14, 16'h7777, wa);
    chk("R7 no acks", 16'(wa), 16'h0);
    checkAll("R7 after foreign write");

    // R8: extra data byte not accepted, commit still occurs
    busStart();
    writeByte({SA, 1'b0}, wa[0]);
    writeByte(8'h15, wa[1]);
    writeByte(8'h34, wa[2]);
    writeByte(8'h12, wa[3]);
    writeByte(8'h99, ak);
    busStop();
    modelWrite(8'h15, 16'h1234);
    chk("R8 extra byte nack", 16'(ak), 16'h0);
    chk("R8 chargeVoltage", chargeVoltage, 16'h1234);
    checkAll("R8 after extra byte");

    // R8: byte read after high byte is released
    busStart(); writeByte({SA, 1'b0}, ak); writeByte(8'h15, ak); busStop();
    busStart(); writeByte({SA, 1'b1}, ak);
    readByte(1'b1, b0); readByte(1'b1, b1); readByte(1'b0, b2);
    busStop();
    chk("R8 read lo", 16'(b0), 16'h34);
    chk("R8 read hi", 16'(b1), 16'h12);
    chk("R8 third byte released", 16'(b2), 16'hFF);

    // R10: master nack on low byte ends the read
    busStart(); writeByte({SA, 1'b0}, ak); writeByte(8'h14, ak); busStop();
    busStart(); writeByte({SA, 1'b1}, ak);
    readByte(1'b0, b0); readByte(1'b0, b1);
    busStop();
    chk("R10 read lo", 16'(b0), 16'hA0);
    chk("R10 after nack released", 16'(b1), 16'hFF);

    // R9: Stop after the low byte
    busStart();
    writeByte({SA, 1'b0}, ak); writeByte(8'h14, ak); writeByte(8'h66, ak);
    busStop();
    checkAll("R9 stop after low byte");

    // R9: Start partway through the high byte
    busStart();
    writeByte({SA, 1'b0}, ak); writeByte(8'h14, ak); writeByte(8'h66, ak);
    for (int i = 0; i < 4; i++) sendBit(1'b0);
    mSda = 1'b1; waitQ();
    mScl = 1'b1; waitQ();
    mSda = 1'b0; waitQ();
    mScl = 1'b0; waitQ();
    busStop();
    checkAll("R9 start mid byte");

    // Random mix
    for (int it = 0; it < 40; it++) begin
      int unsigned op;
      logic [7:0] a;
      logic [15:0] w;
      op = $urandom % 4;
      a  = pickAddr($urandom);
      w  = 16'($urandom);
      case (op)
        0: begin
          busWrite(SA, a, w, wa);
          modelWrite(a, w);
          chk("R2 random write acks", 16'(wa), 16'hF);
        end
        1: begin
          busRead(a, rw, ra);
          chk("R4 random read", rw, expRead(a));
        end
        2: begin
          busStart();
          writeByte({SA, 1'b0}, ak); writeByte(a, ak); writeByte(w[7:0], ak);
          busStop();
        end
        default: begin
          busWrite(SA ^ 7'(1 + ($urandom % 127)), a, w, wa);
          chk("R7 random foreign nack", 16'(wa), 16'h0);
        end
      endcase
      checkAll("R3 random");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule